// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

The block collects forty interrupt lines and presents two requests to a processor. Lines 0x00 to 0x1F form the normal group and drive `irq_o`. Lines 0x20 to 0x27 form the fast group and drive `fiq_o`. Each line has its own settings word and its own trigger-type word. The settings word sets a 4-bit priority and a disable flag. The trigger-type word chooses latched edge capture or sampled level capture.

Software uses a small memory-mapped port with separate read and write strobes. It reads the current-index register to find out which normal source to service. That same read is the acknowledge: it returns the winning index, drops the priority threshold to zero so that both outputs go quiet, and records the returned value in a last-index register that can be read freely. Software re-arms the controller by writing the threshold back. A global disable register can silence the whole controller.

Top module: `vpic_top`

## Requirements
- R1: The settings word of source N sits at byte offset 0x208+4·N. Bits 3:0 hold the priority and bit 6 is a disable flag (1 = disabled). Only those bits are stored, the others read as 0, and the word resets to 0x4F. A disabled source never raises an output, but its capture state is kept.
- R2: A source is eligible when it is pending, not disabled, and its priority is numerically below the threshold. An output is high while any source of its group is eligible. Among eligible normal sources the lowest priority value wins, and a tie goes to the lowest index. A threshold of 0 holds both outputs low.
- R3: A read strobe to offset 0x3F0 while `irq_o` is high returns the winning index on `bus_rdata` in the following cycle. The same read sets the threshold to 0 and clears the latched edge of the winning source.
- R4: A read of offset 0x3F0 while `irq_o` is low returns 0x80 and changes neither the threshold nor any pending state. This covers the case where only fast sources are active, and every read that follows an acknowledge.
- R5: Offset 0x3F4 holds the value returned by the most recent read of 0x3F0 and resets to 0x80. Reading 0x3F4 changes no state.
- R6: Trigger-type value 1 (the reset value) selects edge capture. A rising edge on the line sets a sticky pending bit, and the request shows on the output two cycles after the line rises. A line that stays high does not trigger again. Several edges that arrive before the acknowledge give only one acknowledge.
- R7: Trigger-type value 5, and every value other than 1, selects level capture. The pending state copies the line with a two-cycle delay and is not latched, so a pulse one clock long raises the output for one cycle only.
- R8: The global disable register at offset 0x3FC resets to 0. While it holds 1, both outputs are low, rising edges are not captured, and level pending reads as clear.
- R9: Fast sources 0x20 to 0x27 follow the same eligibility rules as normal sources, including the threshold. They drive only `fiq_o` and are never reported by the index register.
- R10: The threshold register at offset 0x3F8 resets to 0xF, stores bits 3:0 on a write, reads back, and changes only on a write or an acknowledge.
- R11: The trigger-type word of source N sits at offset 0x420+4·N and stores bits 2:0. Writing it clears the source's latched edge, which is the way to clear a fast source set up for edge capture.
- R12: Read data is registered and appears on `bus_rdata` in the cycle after the read strobe. A read of an offset that is not mapped returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_line | input | 40 | Raw interrupt lines, one per source |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a read of 0x3F0 acknowledges |
| bus_rdata | output | 8 | Registered read data |
| irq_o | output | 1 | Request from the normal group |
| fiq_o | output | 1 | Request from the fast group |

## Verification
The assertions check on every cycle that an acknowledge zeroes the threshold, that the threshold changes only through a write or an acknowledge, that an idle index read returns 0x80, that a read with an active request returns a normal-group index, that the last-index register matches the returned data, and that the outputs are silent under a zero threshold or the global disable. Only the directed scenarios can show the order of arbitration among several pending sources, how tied priorities break, how repeated edges merge, that a short level pulse is not retained, and how capture recovers after the global disable is released.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int PRIO_W = 4;
  localparam int TRIG_W = 3;

  localparam logic [DATA_W-1:0] IDLE_IDX   = 8'h80;
  localparam logic [TRIG_W-1:0] TRIG_EDGE  = 3'd1;
  localparam logic [PRIO_W-1:0] MASK_RESET = 4'hF;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 12'h208;
  localparam logic [ADDR_W-1:0] OFS_IDX  = 12'h3F0;
  localparam logic [ADDR_W-1:0] OFS_LAST = 12'h3F4;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h3F8;
  localparam logic [ADDR_W-1:0] OFS_GDIS = 12'h3FC;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 12'h420;

  typedef struct packed {
    logic       hit;
    logic [7:0] slot;
  } slot_t;

  // Map a byte offset onto a word slot of a per-source array
  function automatic slot_t decode_slot(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base,
                                        input int unsigned count);
    slot_t r;
    logic [ADDR_W-1:0] d;
    d      = addr - base;
    r.slot = 8'(d >> 2);
    r.hit  = (addr >= base) && (d[1:0] == 2'b00) && (32'(d >> 2) < count);
    return r;
  endfunction

  function automatic logic is_edge_mode(input logic [TRIG_W-1:0] t);
    return t == TRIG_EDGE;
  endfunction

  function automatic logic below_mask(input logic [PRIO_W-1:0] p,
                                      input logic [PRIO_W-1:0] m);
    return p < m;
  endfunction
endpackage

// File: rtl/vpic_src_cell.sv
module vpic_src_cell
  import vpic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  input  logic              block_i,
  input  logic              cfg_we_i,
  input  logic              trig_we_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic              dis_i,
  input  logic [TRIG_W-1:0] trig_i,
  input  logic              ack_i,
  output logic [PRIO_W-1:0] prio_o,
  output logic              dis_o,
  output logic [TRIG_W-1:0] trig_o,
  output logic              pend_o
);
  logic              line_s, line_p;
  logic [PRIO_W-1:0] prio_q;
  logic              dis_q;
  logic [TRIG_W-1:0] trig_q;
  logic              pend_q;
  logic              rise;
  logic              edge_mode;

  assign edge_mode = is_edge_mode(trig_q);
  assign rise      = line_s & ~line_p & ~block_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_s <= 1'b0;
      line_p <= 1'b0;
    end else begin
      line_s <= line_i;
      line_p <= line_s;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '1;
      dis_q  <= 1'b1;
    end else if (cfg_we_i) begin
      prio_q <= prio_i;
      dis_q  <= dis_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= TRIG_EDGE;
    else if (trig_we_i) trig_q <= trig_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         pend_q <= 1'b0;
    else if (trig_we_i) pend_q <= 1'b0;
    else if (edge_mode) pend_q <= (pend_q & ~ack_i) | rise;
    else                pend_q <= line_s & ~block_i;
  end

  assign prio_o = prio_q;
  assign dis_o  = dis_q;
  assign trig_o = trig_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int N      = 32,
  parameter int BASE   = 0,
  parameter int SLOT_W = 6
) (
  input  logic [N-1:0]             elig_i,
  input  logic [N-1:0][PRIO_W-1:0] prio_i,
  output logic                     any_o,
  output logic [SLOT_W-1:0]        win_o
);
  logic [PRIO_W-1:0] best;

  // Ascending scan with strict compare keeps the lowest index on a tie
  always_comb begin
    any_o = 1'b0;
    win_o = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i] < best)) begin
        any_o = 1'b1;
        best  = prio_i[i];
        win_o = SLOT_W'(BASE + i);
      end
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N_SRC  = 40,
  parameter int N_FAST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_line,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int N_NORM = N_SRC - N_FAST;
  localparam int SLOT_W = $clog2(N_SRC);

  logic [N_SRC-1:0][PRIO_W-1:0] prio_a;
  logic [N_SRC-1:0][TRIG_W-1:0] trig_a;
  logic [N_SRC-1:0]             dis_a, pend_a, elig, ack_vec, cfg_we, trig_we;

  logic [PRIO_W-1:0] mask_q;
  logic [DATA_W-1:0] last_q;
  logic              gdis_q;

  logic              norm_any, fast_any;
  logic [SLOT_W-1:0] norm_win, fast_win;
  logic [DATA_W-1:0] idx_val, rd_val;
  slot_t             cfg_sl, trig_sl;

  // Named events used by the checker
  logic idx_rd, ack_fire, mask_wr, gdis_wr;
  logic unused_wbits, unused_fast_win;

  assign unused_wbits    = ^{bus_wdata[7], bus_wdata[5:4]};
  assign unused_fast_win = ^fast_win;

  assign cfg_sl   = decode_slot(bus_addr, OFS_CFG, N_SRC);
  assign trig_sl  = decode_slot(bus_addr, OFS_TRIG, N_SRC);
  assign idx_rd   = bus_rd && (bus_addr == OFS_IDX);
  assign ack_fire = idx_rd && norm_any;
  assign mask_wr  = bus_wr && (bus_addr == OFS_MASK);
  assign gdis_wr  = bus_wr && (bus_addr == OFS_GDIS);

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign cfg_we[g]  = bus_wr && cfg_sl.hit  && (cfg_sl.slot  == 8'(g));
    assign trig_we[g] = bus_wr && trig_sl.hit && (trig_sl.slot == 8'(g));
    assign elig[g]    = pend_a[g] & ~dis_a[g] & ~gdis_q & below_mask(prio_a[g], mask_q);

    if (g < N_NORM) begin : g_norm_ack
      assign ack_vec[g] = ack_fire && (norm_win == SLOT_W'(g));
    end else begin : g_fast_ack
      assign ack_vec[g] = 1'b0;
    end

    vpic_src_cell u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (src_line[g]),
      .block_i   (gdis_q),
      .cfg_we_i  (cfg_we[g]),
      .trig_we_i (trig_we[g]),
      .prio_i    (bus_wdata[PRIO_W-1:0]),
      .dis_i     (bus_wdata[6]),
      .trig_i    (bus_wdata[TRIG_W-1:0]),
      .ack_i     (ack_vec[g]),
      .prio_o    (prio_a[g]),
      .dis_o     (dis_a[g]),
      .trig_o    (trig_a[g]),
      .pend_o    (pend_a[g])
    );
  end

  vpic_arbiter #(.N(N_NORM), .BASE(0), .SLOT_W(SLOT_W)) u_arb_norm (
    .elig_i (elig[N_NORM-1:0]),
    .prio_i (prio_a[N_NORM-1:0]),
    .any_o  (norm_any),
    .win_o  (norm_win)
  );

  vpic_arbiter #(.N(N_FAST), .BASE(N_NORM), .SLOT_W(SLOT_W)) u_arb_fast (
    .elig_i (elig[N_SRC-1:N_NORM]),
    .prio_i (prio_a[N_SRC-1:N_NORM]),
    .any_o  (fast_any),
    .win_o  (fast_win)
  );

  assign irq_o   = norm_any;
  assign fiq_o   = fast_any;
  assign idx_val = norm_any ? DATA_W'(norm_win) : IDLE_IDX;

  always_ff @(posedge clk) begin
    if (!rst_n)        mask_q <= MASK_RESET;
    else if (ack_fire) mask_q <= '0;
    else if (mask_wr)  mask_q <= bus_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       last_q <= IDLE_IDX;
    else if (idx_rd)  last_q <= idx_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       gdis_q <= 1'b0;
    else if (gdis_wr) gdis_q <= bus_wdata[0];
  end

  always_comb begin
    rd_val = '0;
    unique case (bus_addr)
      OFS_IDX:  rd_val = idx_val;
      OFS_LAST: rd_val = last_q;
      OFS_MASK: rd_val = DATA_W'(mask_q);
      OFS_GDIS: rd_val = DATA_W'(gdis_q);
      default:  rd_val = '0;
    endcase
    for (int i = 0; i < N_SRC; i++) begin
      if (cfg_sl.hit && cfg_sl.slot == 8'(i))
        rd_val = {1'b0, dis_a[i], 2'b00, prio_a[i]};
      if (trig_sl.hit && trig_sl.slot == 8'(i))
        rd_val = DATA_W'(trig_a[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
  import vpic_pkg::*;
#(
  parameter int N_NORM = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_o,
  input logic              fiq_o,
  input logic              idx_rd,
  input logic              ack_fire,
  input logic              mask_wr,
  input logic [PRIO_W-1:0] mask_q,
  input logic [DATA_W-1:0] last_q,
  input logic              gdis_q,
  input logic [DATA_W-1:0] bus_rdata
);
  AST_ACK_ZEROES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> mask_q == '0);  // R3

  AST_ACK_RETURNS_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rd && irq_o) |=> 32'(bus_rdata) < N_NORM);  // R3

  AST_IDLE_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_rd && !irq_o) |=> bus_rdata == IDLE_IDX);  // R4

  AST_LAST_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    idx_rd |=> last_q == bus_rdata);  // R5

  AST_LAST_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_rd |=> $stable(last_q));  // R5

  AST_ZERO_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> (!irq_o && !fiq_o));  // R2

  AST_GDIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    gdis_q |-> (!irq_o && !fiq_o));  // R8

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_fire && !mask_wr) |=> $stable(mask_q));  // R10
endmodule

bind vpic_top vpic_checker #(.N_NORM(N_NORM)) u_vpic_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .idx_rd    (idx_rd),
  .ack_fire  (ack_fire),
  .mask_wr   (mask_wr),
  .mask_q    (mask_q),
  .last_q    (last_q),
  .gdis_q    (gdis_q),
  .bus_rdata (bus_rdata)
);

// File: tb/vpic_top_tb.sv
module vpic_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 40;

  localparam logic [11:0] A_IDX  = 12'h3F0;
  localparam logic [11:0] A_LAST = 12'h3F4;
  localparam logic [11:0] A_MASK = 12'h3F8;
  localparam logic [11:0] A_GDIS = 12'h3FC;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_line = '0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [7:0]    bus_rdata;
  logic          irq_o, fiq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vpic_top dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_line  (src_line),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o),
    .fiq_o     (fiq_o)
  );

  function automatic logic [11:0] cfg_a(input int n);
    return 12'(12'h208 + 4 * n);
  endfunction

  function automatic logic [11:0] trig_a(input int n);
    return 12'(12'h420 + 4 * n);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [NS-1:0] bits);
    @(negedge clk); src_line = src_line | bits;
    @(negedge clk); src_line = src_line & ~bits;
    settle(2);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R2", "irq after reset", 32'(irq_o), 0);
    check("R9", "fiq after reset", 32'(fiq_o), 0);
    rd(A_IDX, d);   check("R4", "idle index", 32'(d), 32'h80);
    rd(A_LAST, d);  check("R5", "last reset", 32'(d), 32'h80);
    rd(A_MASK, d);  check("R10", "mask reset", 32'(d), 32'hF);
    rd(A_GDIS, d);  check("R8", "gdis reset", 32'(d), 0);
    rd(cfg_a(0), d); check("R1", "cfg reset", 32'(d), 32'h4F);
    rd(trig_a(0), d); check("R11", "trig reset", 32'(d), 1);
    rd(12'h100, d); check("R12", "unmapped read", 32'(d), 0);
  endtask

  task automatic t_cfg_fields();
    logic [7:0] d;
    wr(cfg_a(5), 8'hB3); rd(cfg_a(5), d);
    check("R1", "cfg stored bits", 32'(d), 32'h03);
    wr(cfg_a(5), 8'hFA); rd(cfg_a(5), d);
    check("R1", "cfg disable bit", 32'(d), 32'h4A);
    wr(trig_a(5), 8'hFD); rd(trig_a(5), d);
    check("R11", "trig stored bits", 32'(d), 32'h5);
    wr(trig_a(5), 8'h01);
    wr(A_MASK, 8'hF7); rd(A_MASK, d);
    check("R10", "mask write", 32'(d), 32'h7);
    wr(A_MASK, 8'h0F);
  endtask

  task automatic t_arbitrate();
    logic [7:0] d;
    wr(cfg_a(3), 8'h05); wr(cfg_a(7), 8'h02); wr(cfg_a(9), 8'h02);
    pulse((40'd1 << 3) | (40'd1 << 7) | (40'd1 << 9));
    check("R6", "irq after edges", 32'(irq_o), 1);
    rd(A_IDX, d);  check("R2", "lowest prio, lower index wins", 32'(d), 7);
    check("R3", "irq quiet after ack", 32'(irq_o), 0);
    rd(A_MASK, d); check("R3", "mask zeroed", 32'(d), 0);
    rd(A_LAST, d); check("R5", "last copy", 32'(d), 7);
    rd(A_LAST, d); check("R5", "last reread", 32'(d), 7);
    rd(A_MASK, d); check("R5", "mask untouched by last read", 32'(d), 0);
    rd(A_IDX, d);  check("R4", "index after ack", 32'(d), 32'h80);
    rd(A_LAST, d); check("R5", "last after idle read", 32'(d), 32'h80);
    wr(A_MASK, 8'h0F);
    rd(A_IDX, d);  check("R2", "tie partner next", 32'(d), 9);
    wr(A_MASK, 8'h0F);
    rd(A_IDX, d);  check("R2", "highest value last", 32'(d), 3);
    wr(A_MASK, 8'h0F);
    rd(A_IDX, d);  check("R6", "all edges cleared", 32'(d), 32'h80);
    check("R6", "irq low", 32'(irq_o), 0);
  endtask

  task automatic t_threshold();
    logic [7:0] d;
    wr(A_MASK, 8'h05);
    pulse(40'd1 << 3);
    check("R2", "prio equal to mask blocked", 32'(irq_o), 0);
    wr(A_MASK, 8'h06);
    check("R2", "prio below mask passes", 32'(irq_o), 1);
    rd(A_IDX, d); check("R3", "index 3", 32'(d), 3);
    wr(A_MASK, 8'h0F);
  endtask

  task automatic t_disable_bit();
    logic [7:0] d;
    wr(cfg_a(4), 8'h41);
    pulse(40'd1 << 4);
    check("R1", "disabled source quiet", 32'(irq_o), 0);
    rd(A_IDX, d); check("R4", "disabled not reported", 32'(d), 32'h80);
    wr(cfg_a(4), 8'h01);
    check("R1", "enable exposes held edge", 32'(irq_o), 1);
    rd(A_IDX, d); check("R3", "index 4", 32'(d), 4);
    wr(A_MASK, 8'h0F);
    wr(cfg_a(4), 8'h41);
  endtask

  task automatic t_level();
    logic [7:0] d;
    wr(cfg_a(12), 8'h01); wr(trig_a(12), 8'h05);
    @(negedge clk); src_line[12] = 1'b1;
    settle(2);
    check("R7", "level raises irq", 32'(irq_o), 1);
    rd(A_IDX, d); check("R3", "level index", 32'(d), 12);
    wr(A_MASK, 8'h0F);
    check("R7", "level still pending after ack", 32'(irq_o), 1);
    @(negedge clk); src_line[12] = 1'b0;
    settle(2);
    check("R7", "level follows line low", 32'(irq_o), 0);
    @(negedge clk); src_line[12] = 1'b1;
    @(negedge clk); src_line[12] = 1'b0;
    @(negedge clk);
    check("R7", "short pulse seen one cycle", 32'(irq_o), 1);
    @(negedge clk);
    check("R7", "short pulse not held", 32'(irq_o), 0);
    rd(A_IDX, d); check("R7", "short pulse not reported", 32'(d), 32'h80);
    wr(trig_a(12), 8'h03);
    @(negedge clk); src_line[12] = 1'b1;
    settle(2);
    check("R7", "other code is level", 32'(irq_o), 1);
    @(negedge clk); src_line[12] = 1'b0;
    settle(2);
    check("R7", "other code drops", 32'(irq_o), 0);
    wr(cfg_a(12), 8'h41); wr(trig_a(12), 8'h01);
  endtask

  task automatic t_edge_merge();
    logic [7:0] d;
    wr(cfg_a(8), 8'h03);
    pulse(40'd1 << 8);
    pulse(40'd1 << 8);
    rd(A_IDX, d); check("R6", "merged edge index", 32'(d), 8);
    wr(A_MASK, 8'h0F);
    rd(A_IDX, d); check("R6", "second edge merged", 32'(d), 32'h80);
    wr(cfg_a(10), 8'h04);
    @(negedge clk); src_line[10] = 1'b1;
    settle(2);
    rd(A_IDX, d); check("R6", "held line index", 32'(d), 10);
    wr(A_MASK, 8'h0F);
    settle(3);
    check("R6", "held line no retrigger", 32'(irq_o), 0);
    @(negedge clk); src_line[10] = 1'b0;
  endtask

  task automatic t_fast();
    logic [7:0] d;
    wr(cfg_a(34), 8'h01); wr(trig_a(34), 8'h05);
    @(negedge clk); src_line[34] = 1'b1;
    settle(2);
    check("R9", "fiq raised", 32'(fiq_o), 1);
    check("R9", "irq untouched", 32'(irq_o), 0);
    rd(A_IDX, d); check("R9", "index ignores fast", 32'(d), 32'h80);
    rd(A_MASK, d); check("R4", "idle read keeps mask", 32'(d), 32'hF);
    wr(A_MASK, 8'h01);
    check("R9", "fast obeys mask", 32'(fiq_o), 0);
    wr(A_MASK, 8'h0F);
    check("R9", "fiq back", 32'(fiq_o), 1);
    @(negedge clk); src_line[34] = 1'b0;
    settle(2);
    check("R9", "fiq drops", 32'(fiq_o), 0);
  endtask

  task automatic t_global_disable();
    logic [7:0] d;
    wr(A_GDIS, 8'h01);
    rd(A_GDIS, d); check("R8", "gdis reads 1", 32'(d), 1);
    @(negedge clk); src_line[34] = 1'b1;
    pulse(40'd1 << 3);
    check("R8", "irq blocked", 32'(irq_o), 0);
    check("R8", "fiq blocked", 32'(fiq_o), 0);
    wr(A_GDIS, 8'h00);
    settle(2);
    check("R8", "edge during disable lost", 32'(irq_o), 0);
    check("R8", "level resumes", 32'(fiq_o), 1);
    @(negedge clk); src_line[34] = 1'b0;
    settle(2);
  endtask

  task automatic t_trig_clear();
    logic [7:0] d;
    wr(cfg_a(6), 8'h02);
    pulse(40'd1 << 6);
    check("R11", "edge pending", 32'(irq_o), 1);
    wr(trig_a(6), 8'h01);
    check("R11", "trig write clears", 32'(irq_o), 0);
    rd(A_IDX, d); check("R11", "nothing left", 32'(d), 32'h80);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    settle(4);
    rst_n = 1'b1;
    settle(1);
    t_reset();
    t_cfg_fields();
    t_arbitrate();
    t_threshold();
    t_disable_bit();
    t_level();
    t_edge_merge();
    t_fast();
    t_global_disable();
    t_trig_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule